// File: doc/BRIEF.md
# Interleaved burst-correcting memory ECC

This block guards a 16-bit memory word against upsets that flip several neighbouring cells at once. On the write side it cuts the data into two 8-bit halves. It gives each half five check bits from a (13,8) code that repairs one flipped bit or two flipped neighbours. It then weaves the two 13-bit codewords together bit by bit, so the stored word is 26 bits wide and any two physically adjacent cells belong to different halves. The result is that a burst of up to four adjacent upsets lands as at most two adjacent errors in each half, and both halves can repair that.

On the read side the block separates the two codewords again. It forms a 5-bit syndrome for each one and matches it against the 25 patterns the code can repair. It then applies the matching flip mask to that half's data bits. Each half reports on its own whether it repaired something or saw a pattern it cannot repair. Both paths are combinational. A parameter adds one output register stage, and that stage is on by default.

Top module: `burst_ecc_codec`

## Requirements
- R1: In the stored word, physical bit 2k holds component bit k of half A and bit 2k+1 holds component bit k of half B (k = 0..12). Component bits 0..7 carry data unchanged: half A is data[7:0] and half B is data[15:8]. Component bits 8..12 carry the check bits.
- R2: For the component codeword bits 0..12, the 5-bit parity columns are 31, 5, 10, 13, 19, 14, 28, 21, 1, 2, 4, 8, 16, where bit 0 of each column is its LSB. Syndrome bit i is the XOR of the received bits whose column has bit i set. A freshly encoded word decodes to its own data with all flags low.
- R3: A flip of any one of the 26 stored bits is repaired. The repaired flag rises for the half that holds that bit and stays low for the other half.
- R4: A burst of 2, 3 or 4 physically adjacent flipped bits is repaired wherever it starts, and both halves raise the repaired flag.
- R5: Two flips in different halves, at any positions, are both repaired, and both repaired flags rise.
- R6: A nonzero syndrome that matches none of the 13 single or 12 adjacent-pair patterns raises that half's uncorrectable flag and passes the received data bits through unaltered. Two examples: flipping component bits 8 and 12 gives syndrome 17, and flipping component data bits 1 and 4 gives syndrome 22.
- R7: With the output register on, every output shows the result for the inputs that were present one rising clock edge earlier. While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 16 | Data word to encode |
| enc_word | output | 26 | Interleaved codeword to store |
| rd_word | input | 26 | Codeword read back from storage |
| rd_data | output | 16 | Repaired data |
| half_fixed | output | 2 | Repair flag per half (bit 0 = half A) |
| half_bad | output | 2 | Uncorrectable flag per half (bit 0 = half A) |

## Verification
Every result, both the encoded word and the decoded data and flags, is due exactly one rising edge after its input is applied. The driver applies inputs on the falling edge and tags each expected item in the scoreboard queue with the cycle number after that edge. The monitor compares only items whose tag matches the current cycle, and it samples on the falling edge, half a period clear of the register update. A dedicated hold test changes the read word just after a result has appeared and confirms that the old result stays until the next rising edge.

// File: rtl/ilv_ecc_pkg.sv
`timescale 1ns/1ps
package ilv_ecc_pkg;

    localparam int HALF_DW = 8;
    localparam int CHK_W   = 5;
    localparam int CW_W    = HALF_DW + CHK_W;
    localparam int WAYS    = 2;
    localparam int DATA_W  = WAYS * HALF_DW;
    localparam int WORD_W  = WAYS * CW_W;
    localparam int NPAIR   = CW_W - 1;

    typedef logic [CHK_W-1:0]   syn_t;
    typedef logic [CW_W-1:0]    cw_t;
    typedef logic [HALF_DW-1:0] half_t;

    typedef struct packed {
        logic [WORD_W-1:0] enc;
        logic [DATA_W-1:0] data;
        logic [WAYS-1:0]   fixed;
        logic [WAYS-1:0]   bad;
    } codec_out_t;

    // Parity column per component position; singles and neighbour XORs are all distinct.
    function automatic syn_t hcol(input int p);
        syn_t c;
        case (p)
            0:       c = 5'd31;
            1:       c = 5'd5;
            2:       c = 5'd10;
            3:       c = 5'd13;
            4:       c = 5'd19;
            5:       c = 5'd14;
            6:       c = 5'd28;
            7:       c = 5'd21;
            8:       c = 5'd1;
            9:       c = 5'd2;
            10:      c = 5'd4;
            11:      c = 5'd8;
            12:      c = 5'd16;
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic syn_t cw_syndrome(input cw_t cw);
        syn_t s;
        s = '0;
        for (int p = 0; p < CW_W; p++) begin
            if (cw[p]) s = s ^ hcol(p);
        end
        return s;
    endfunction

    // Systematic data bits pulled straight out of an interleaved word.
    function automatic logic [DATA_W-1:0] word_data(input logic [WORD_W-1:0] w);
        logic [DATA_W-1:0] d;
        for (int h = 0; h < WAYS; h++) begin
            for (int k = 0; k < HALF_DW; k++) begin
                d[h*HALF_DW + k] = w[k*WAYS + h];
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ilv_half_enc.sv
`timescale 1ns/1ps
module ilv_half_enc import ilv_ecc_pkg::*; (
    input  half_t data_i,
    output cw_t   cw_o
);

    syn_t chk;

    // Check columns are unit vectors, so the check bits equal the data-only syndrome.
    always_comb begin
        chk  = cw_syndrome({{CHK_W{1'b0}}, data_i});
        cw_o = {chk, data_i};
    end

endmodule

// File: rtl/ilv_half_dec.sv
`timescale 1ns/1ps
module ilv_half_dec import ilv_ecc_pkg::*; (
    input  cw_t   cw_i,
    output half_t data_o,
    output logic  fixed_o,
    output logic  bad_o
);

    syn_t             syn;
    logic [CW_W-1:0]  hit_one;
    logic [NPAIR-1:0] hit_pair;
    cw_t              mask;

    assign syn = cw_syndrome(cw_i);

    for (genvar p = 0; p < CW_W; p++) begin : g_one
        assign hit_one[p] = (syn == hcol(p));
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign hit_pair[p] = (syn == (hcol(p) ^ hcol(p + 1)));
    end

    for (genvar p = 0; p < CW_W; p++) begin : g_mask
        if (p == 0) begin : g_lo
            assign mask[p] = hit_one[p] | hit_pair[p];
        end else if (p == CW_W - 1) begin : g_hi
            assign mask[p] = hit_one[p] | hit_pair[p-1];
        end else begin : g_mid
            assign mask[p] = hit_one[p] | hit_pair[p] | hit_pair[p-1];
        end
    end

    always_comb begin
        data_o  = cw_i[HALF_DW-1:0] ^ mask[HALF_DW-1:0];
        fixed_o = |mask;
        bad_o   = (|syn) & ~(|mask);
    end

    always_comb begin
        AST_ONE_MATCH: assert ($onehot0({hit_pair, hit_one})) // R2
            else $error("more than one repair pattern matched");
        if (|mask) begin
            AST_RESYN_ZERO: assert (cw_syndrome(cw_i ^ mask) == '0) // R3
                else $error("repaired codeword still has a syndrome");
        end
        AST_MASK_SPAN: assert ($countones(mask) <= 2) // R4
            else $error("repair mask touches more than two bits");
        if (bad_o) begin
            AST_BAD_PASS: assert (data_o == cw_i[HALF_DW-1:0]) // R6
                else $error("uncorrectable half altered its data");
        end
    end

endmodule

// File: rtl/ilv_lane_map.sv
`timescale 1ns/1ps
module ilv_lane_map import ilv_ecc_pkg::*; (
    input  logic [WAYS-1:0][CW_W-1:0] cw_in,
    output logic [WORD_W-1:0]         word_out,
    input  logic [WORD_W-1:0]         word_in,
    output logic [WAYS-1:0][CW_W-1:0] cw_out
);

    for (genvar k = 0; k < CW_W; k++) begin : g_pos
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign word_out[k*WAYS + w] = cw_in[w][k];
            assign cw_out[w][k]         = word_in[k*WAYS + w];
        end
    end

endmodule

// File: rtl/burst_ecc_codec.sv
`timescale 1ns/1ps
module burst_ecc_codec import ilv_ecc_pkg::*; #(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [WORD_W-1:0] enc_word,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic [WAYS-1:0]   half_fixed,
    output logic [WAYS-1:0]   half_bad
);

    logic [WAYS-1:0][CW_W-1:0] enc_cw;
    logic [WAYS-1:0][CW_W-1:0] dec_cw;
    logic [WORD_W-1:0]         enc_flat;
    logic [DATA_W-1:0]         dec_data;
    logic [WAYS-1:0]           dec_fixed;
    logic [WAYS-1:0]           dec_bad;
    codec_out_t                st_d;
    codec_out_t                st_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        ilv_half_enc u_enc (
            .data_i (wr_data[w*HALF_DW +: HALF_DW]),
            .cw_o   (enc_cw[w])
        );
        ilv_half_dec u_dec (
            .cw_i    (dec_cw[w]),
            .data_o  (dec_data[w*HALF_DW +: HALF_DW]),
            .fixed_o (dec_fixed[w]),
            .bad_o   (dec_bad[w])
        );
    end

    ilv_lane_map u_map (
        .cw_in    (enc_cw),
        .word_out (enc_flat),
        .word_in  (rd_word),
        .cw_out   (dec_cw)
    );

    always_comb begin
        st_d       = '0;
        st_d.enc   = enc_flat;
        st_d.data  = dec_data;
        st_d.fixed = dec_fixed;
        st_d.bad   = dec_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    if (REG_OUT) begin : g_reg
        assign enc_word   = st_q.enc;
        assign rd_data    = st_q.data;
        assign half_fixed = st_q.fixed;
        assign half_bad   = st_q.bad;

        logic [DATA_W-1:0] raw_data;
        logic              dec_any;
        assign raw_data = word_data(rd_word);
        assign dec_any  = |{dec_fixed, dec_bad};

        AST_ENC_SYSTEMATIC: assert property (@(posedge clk) disable iff (!rst_n) // R1
            $past(rst_n) |-> (word_data(enc_word) == $past(wr_data)))
            else $error("stored word does not carry the written data");

        AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n) // R7
            ($past(rst_n) && !$past(dec_any)) |-> (rd_data == $past(raw_data)))
            else $error("clean read did not appear one edge later");
    end else begin : g_comb
        assign enc_word   = st_d.enc;
        assign rd_data    = st_d.data;
        assign half_fixed = st_d.fixed;
        assign half_bad   = st_d.bad;
    end

endmodule

// File: tb/burst_ecc_codec_tb.sv
`timescale 1ns/1ps
module burst_ecc_codec_tb;
    import ilv_ecc_pkg::*;

    logic              clk   = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [WORD_W-1:0] rd_word = '0;
    logic [WORD_W-1:0] enc_word;
    logic [DATA_W-1:0] rd_data;
    logic [WAYS-1:0]   half_fixed;
    logic [WAYS-1:0]   half_bad;

    burst_ecc_codec #(.REG_OUT(1'b1)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data    (wr_data),
        .enc_word   (enc_word),
        .rd_word    (rd_word),
        .rd_data    (rd_data),
        .half_fixed (half_fixed),
        .half_bad   (half_bad)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        int          due;
        logic [15:0] data;
        logic [1:0]  fx;
        logic [1:0]  bd;
        string       req;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: compares each queued item in the cycle it is due.
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            e = sb.pop_front();
            chk(e.req, "data",  32'(rd_data),    32'(e.data));
            chk(e.req, "fixed", 32'(half_fixed), 32'(e.fx));
            chk(e.req, "bad",   32'(half_bad),   32'(e.bd));
        end
    end

    // Encode one word; also checks the systematic layout (R1).
    task automatic encode(input logic [15:0] d, output logic [25:0] w);
        logic [15:0] got;
        @(negedge clk);
        wr_data = d;
        @(negedge clk);
        w = enc_word;
        for (int k = 0; k < 8; k++) begin
            got[k]     = w[2*k];
            got[8 + k] = w[2*k + 1];
        end
        chk("R1", "systematic layout", 32'(got), 32'(d));
    endtask

    task automatic send(input logic [25:0] w, input logic [15:0] d,
                        input logic [1:0] fx, input logic [1:0] bd, input string req);
        exp_t e;
        @(negedge clk);
        rd_word = w;
        e.due  = cyc + 1;
        e.data = d;
        e.fx   = fx;
        e.bd   = bd;
        e.req  = req;
        sb.push_back(e);
    endtask

    // Repairable error pattern: every half that is hit gets its repair flag.
    task automatic run_err(input logic [15:0] d, input logic [25:0] err, input string req);
        logic [25:0] w;
        logic [1:0]  fx;
        fx = 2'b00;
        for (int i = 0; i < 26; i++) begin
            if (err[i]) fx[i % 2] = 1'b1;
        end
        encode(d, w);
        send(w ^ err, d, fx, 2'b00, req);
    endtask

    task automatic run_bad(input logic [15:0] d, input logic [25:0] err,
                           input logic [15:0] exp_d, input logic [1:0] fx,
                           input logic [1:0] bd);
        logic [25:0] w;
        encode(d, w);
        send(w ^ err, exp_d, fx, bd, "R6");
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [25:0] w1;
        logic [25:0] w2;
        logic [25:0] err;
        logic [15:0] d;
        logic [15:0] fixed_pats [4];

        // R7: reset holds every output at zero, whatever the inputs are.
        wr_data = 16'hBEEF;
        rd_word = '1;
        repeat (3) @(negedge clk);
        chk("R7", "reset enc_word",   32'(enc_word),   32'h0);
        chk("R7", "reset rd_data",    32'(rd_data),    32'h0);
        chk("R7", "reset half_fixed", 32'(half_fixed), 32'h0);
        chk("R7", "reset half_bad",   32'(half_bad),   32'h0);
        rst_n = 1'b1;

        // R2: clean round trips on fixed and random words.
        fixed_pats[0] = 16'h0000;
        fixed_pats[1] = 16'hFFFF;
        fixed_pats[2] = 16'hA5C3;
        fixed_pats[3] = 16'h0180;
        for (int i = 0; i < 4; i++) run_err(fixed_pats[i], '0, "R2");
        for (int i = 0; i < 16; i++) run_err(16'($urandom()), '0, "R2");

        // R3: every single-bit flip.
        for (int i = 0; i < 26; i++) begin
            err = '0;
            err[i] = 1'b1;
            run_err(16'($urandom()), err, "R3");
        end

        // R4: every adjacent burst of 2, 3 and 4 bits.
        for (int len = 2; len <= 4; len++) begin
            for (int s = 0; s + len <= 26; s++) begin
                err = '0;
                for (int b = 0; b < len; b++) err[s + b] = 1'b1;
                run_err(16'($urandom()), err, "R4");
            end
        end

        // R5: random pairs, one flip per half.
        for (int n = 0; n < 120; n++) begin
            err = '0;
            err[2 * $urandom_range(12, 0)]     = 1'b1;
            err[2 * $urandom_range(12, 0) + 1] = 1'b1;
            run_err(16'($urandom()), err, "R5");
        end

        // R6: unmatched syndromes.
        d = 16'h3C5A;
        err = '0; err[16] = 1'b1; err[24] = 1'b1;
        run_bad(d, err, d, 2'b00, 2'b01);
        err = '0; err[17] = 1'b1; err[25] = 1'b1;
        run_bad(d, err, d, 2'b00, 2'b10);
        err = '0; err[2] = 1'b1; err[8] = 1'b1;
        run_bad(d, err, d ^ 16'h0012, 2'b00, 2'b01);
        err = '0; err[16] = 1'b1; err[24] = 1'b1; err[5] = 1'b1;
        run_bad(d, err, d, 2'b10, 2'b01);

        // R7: a result holds until the next rising edge, then follows the new word.
        while (sb.size() > 0) @(negedge clk);
        encode(16'h1234, w1);
        encode(16'hFEDC, w2);
        @(negedge clk);
        rd_word = w1;
        @(negedge clk);
        rd_word = w2;
        #1;
        chk("R7", "hold before edge", 32'(rd_data), 32'h1234);
        @(negedge clk);
        chk("R7", "update after edge", 32'(rd_data), 32'hFEDC);

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule